// File: doc/BRIEF.md
# Interrupt Vector Fetch Unit

This unit turns an accepted interrupt into a 20-bit branch target. The requester gives a source: either one of nine fixed events, or a vector number into a relocatable table. The requester also gives a 20-bit table base. The unit works out the byte address of the 4-byte vector entry. It reads the entry through a 16-bit read port that has a ready handshake, and it assembles the target from the low three bytes. It then reports the target with a single-cycle done strobe.

Fixed events use a table at the very top of the address space. Relocatable vectors use a 256-byte table that starts at the table base. The break event has a fallback. A probe read checks the byte at 0xFFFE7. If that byte is 0xFF, the vector comes from a configurable slot of the relocatable table instead of the fixed entry. An entry at an even address needs two reads. An entry at an odd address needs three reads, and a byte-lane shifter realigns the bytes.

Top module: `int_vector_fetch`

## Requirements
- R1: After reset, `busy`, `memRd` and `done` are 0 and `vecAddr` is 0. Reset also aborts an operation in progress.
- R2: The target is assembled from the entry bytes at E, E+1 and E+2 (low byte first), as `vecAddr = {byte(E+2)[3:0], byte(E+1), byte(E)}`. The upper nibble of byte E+2 and the byte at E+3 have no effect.
- R3: With `srcKind`=0, `srcNum` selects a fixed event at E = 0xFFFDC + 4·code. The codes are: 0 undefined instruction, 1 overflow, 2 break, 3 address match, 4 single step, 5 oscillator-stop/watchdog, 6 debug, 7 NMI, 8 reset. Codes 9 to 63 select the reset entry 0xFFFFC.
- R4: With `srcKind`=1, the entry is E = (`tableBase` + 4·`srcNum`) mod 2^20.
- R5: Reset code 8 always fetches from 0xFFFFC, whatever `tableBase` holds.
- R6: A read holds `memRd`=1 with an even byte address on `memAddr` until `memReady` is 1 at a rising clock edge. `memRdata[7:0]` is the byte at `memAddr` and `memRdata[15:8]` is the byte at `memAddr`+1.
- R7: An even entry address takes exactly two reads, at E and E+2.
- R8: An odd entry address takes exactly three reads, at E−1, E+1 and E+3, with addresses wrapping modulo 2^20.
- R9: For break (code 2) the first read is at 0xFFFE6. If its upper byte is 0xFF, the entry is `tableBase` + 4·`BRK_SLOT` (default slot 0). Otherwise the entry is 0xFFFE4.
- R10: `done` is high for exactly one cycle, the cycle after the last read is accepted. In that cycle `busy` is 0 and `vecAddr` holds the target, which then stays stable until the next done.
- R11: A `req` seen while `busy` is 1 is ignored.
- R12: A `req` seen while `busy` is 0 is accepted at that edge, and `busy` is 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request a vector fetch |
| srcKind | input | 1 | 0 = fixed event, 1 = relocatable vector number |
| srcNum | input | 6 | Fixed event code or vector number |
| tableBase | input | 20 | Relocatable table base address |
| busy | output | 1 | Fetch in progress |
| memAddr | output | 20 | Even byte address of the current read |
| memRd | output | 1 | Read request |
| memRdata | input | 16 | Read data, lower byte at the lower address |
| memReady | input | 1 | Read complete this cycle |
| vecAddr | output | 20 | Assembled target address |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions assume that the memory side raises `memReady` only while `memRd` is high. They also assume that `req`, `srcKind`, `srcNum` and `tableBase` are stable around the accepting edge. The bench's memory model answers only pending reads, after 0 to 2 wait cycles. Its contents come from a fixed byte-address formula, and 0xFFFE7 is under test control. All stimulus is driven on the falling edge, so request fields never change near an accepting edge.

// File: rtl/ivf_pkg.sv
package ivf_pkg;

  // Sequencer states: idle, break-flag probe, and entry fetch.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_FETCH = 2'd2
  } ivfState_e;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic latchReq;
    logic probeDone;
    logic beat;
    logic finish;
  } ivfStrobe_t;

  // Status from the datapath back to the control module.
  typedef struct packed {
    logic reqIsBrk;
    logic entryOdd;
  } ivfStatus_t;

  localparam int unsigned FIXED_COUNT = 9;
  localparam int unsigned CODE_BRK    = 2;
  localparam int unsigned CODE_RESET  = 8;
  localparam int unsigned BYTE_W      = 8;

endpackage

// File: rtl/ivf_datapath.sv
module ivf_datapath
  import ivf_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_W    = 6,
  parameter int unsigned BRK_SLOT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ivfStrobe_t        stb,
  input  logic              srcKind,
  input  logic [NUM_W-1:0]  srcNum,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [DATA_W-1:0] memRdata,
  output ivfStatus_t        status,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] vecAddr
);

  // Fixed table sits in the top 4*FIXED_COUNT bytes of the space.
  localparam logic [ADDR_W-1:0] FIX_BASE   = ADDR_W'((1 << ADDR_W) - 4 * FIXED_COUNT);
  localparam logic [ADDR_W-1:0] BRK_ENTRY  = FIX_BASE + ADDR_W'(4 * CODE_BRK);
  localparam logic [ADDR_W-1:0] PROBE_ADDR = BRK_ENTRY + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] RST_ENTRY  = FIX_BASE + ADDR_W'(4 * CODE_RESET);
  localparam int unsigned       BUF_W      = DATA_W + BYTE_W;
  localparam int unsigned       HI_BITS    = ADDR_W - 2 * BYTE_W;

  logic              kindR;
  logic [NUM_W-1:0]  numR;
  logic [ADDR_W-1:0] baseR;
  logic              fbR;
  logic [BUF_W-1:0]  shBuf;
  logic [ADDR_W-1:0] curEntry;
  logic              probeHit;
  logic [ADDR_W-1:0] evenVec;
  logic [ADDR_W-1:0] oddVec;

  function automatic logic [ADDR_W-1:0] calcEntry(
    input logic              kind,
    input logic [NUM_W-1:0]  num,
    input logic [ADDR_W-1:0] base,
    input logic              fallback
  );
    logic [ADDR_W-1:0] e;
    if (kind)                              e = base + (ADDR_W'(num) << 2);
    else if (fallback)                     e = base + ADDR_W'(4 * BRK_SLOT);
    else if (num >= NUM_W'(FIXED_COUNT))   e = RST_ENTRY;
    else                                   e = FIX_BASE + (ADDR_W'(num) << 2);
    return e;
  endfunction

  function automatic logic [ADDR_W-1:0] wordOf(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:1], 1'b0};
  endfunction

  assign curEntry        = calcEntry(kindR, numR, baseR, fbR);
  assign probeHit        = (memRdata[DATA_W-1 -: BYTE_W] == {BYTE_W{1'b1}});
  assign status.reqIsBrk = !srcKind && (srcNum == NUM_W'(CODE_BRK));
  assign status.entryOdd = curEntry[0];

  // Byte-lane realignment: even entries finish on the second word, odd on the third.
  assign evenVec = {memRdata[HI_BITS-1:0], shBuf[BUF_W-1:BYTE_W]};
  assign oddVec  = shBuf[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindR   <= 1'b0;
      numR    <= '0;
      baseR   <= '0;
      fbR     <= 1'b0;
      rdAddr  <= '0;
      shBuf   <= '0;
      vecAddr <= '0;
    end else begin
      if (stb.latchReq) begin
        kindR  <= srcKind;
        numR   <= srcNum;
        baseR  <= tableBase;
        fbR    <= 1'b0;
        rdAddr <= status.reqIsBrk ? PROBE_ADDR
                                  : wordOf(calcEntry(srcKind, srcNum, tableBase, 1'b0));
      end
      if (stb.probeDone) begin
        fbR    <= probeHit;
        rdAddr <= wordOf(calcEntry(kindR, numR, baseR, probeHit));
      end
      if (stb.beat) begin
        shBuf  <= {memRdata, shBuf[BUF_W-1 -: BYTE_W]};
        rdAddr <= rdAddr + ADDR_W'(2);
      end
      if (stb.finish) begin
        vecAddr <= status.entryOdd ? oddVec : evenVec;
      end
    end
  end

  // R5: a reset-code request aims its first read at the top entry.
  assert_reset_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.latchReq && !srcKind && (srcNum == NUM_W'(CODE_RESET)) |=> rdAddr == RST_ENTRY);

  // R9: a break request probes the flag word first.
  assert_brk_probe_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.latchReq && !srcKind && (srcNum == NUM_W'(CODE_BRK)) |=> rdAddr == PROBE_ADDR);

endmodule

// File: rtl/ivf_ctrl.sv
module ivf_ctrl
  import ivf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       req,
  input  logic       memReady,
  input  ivfStatus_t status,
  output ivfStrobe_t stb,
  output logic       busy,
  output logic       memRd,
  output logic       done
);

  ivfState_e state;
  ivfState_e nextState;
  logic [1:0] beatCnt;
  logic       lastBeat;

  assign lastBeat = (beatCnt == (status.entryOdd ? 2'd2 : 2'd1));
  assign busy     = (state != ST_IDLE);
  assign memRd    = busy;

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (req) begin
          stb.latchReq = 1'b1;
          nextState    = status.reqIsBrk ? ST_PROBE : ST_FETCH;
        end
      end
      ST_PROBE: begin
        if (memReady) begin
          stb.probeDone = 1'b1;
          nextState     = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (memReady) begin
          stb.beat = 1'b1;
          if (lastBeat) begin
            stb.finish = 1'b1;
            nextState  = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
      done    <= 1'b0;
    end else begin
      state <= nextState;
      done  <= stb.finish;
      if (state != ST_FETCH)  beatCnt <= '0;
      else if (memReady)      beatCnt <= beatCnt + 2'd1;
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_accept_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busy && req |=> busy);

endmodule

// File: rtl/int_vector_fetch.sv
module int_vector_fetch
  import ivf_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_W    = 6,
  parameter int unsigned BRK_SLOT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              srcKind,
  input  logic [NUM_W-1:0]  srcNum,
  input  logic [ADDR_W-1:0] tableBase,
  output logic              busy,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              done
);

  ivfStrobe_t stb;
  ivfStatus_t status;

  ivf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .req      (req),
    .memReady (memReady),
    .status   (status),
    .stb      (stb),
    .busy     (busy),
    .memRd    (memRd),
    .done     (done)
  );

  ivf_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_W    (NUM_W),
    .BRK_SLOT (BRK_SLOT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .srcKind   (srcKind),
    .srcNum    (srcNum),
    .tableBase (tableBase),
    .memRdata  (memRdata),
    .status    (status),
    .rdAddr    (memAddr),
    .vecAddr   (vecAddr)
  );

  // R6: a pending read keeps its address until accepted.
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    memRd && !memReady |=> memRd && $stable(memAddr));

  // R6: every read address is word aligned.
  assert_even_R6: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> memAddr[0] == 1'b0);

endmodule

// File: tb/int_vector_fetch_tb.sv
module int_vector_fetch_tb;

  typedef struct packed {
    logic        kind;
    logic [5:0]  num;
    logic [19:0] base;
    logic        ff;
    logic [19:0] entry;
    logic [19:0] first;
    logic [2:0]  nRd;
    logic [3:0]  reqId;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd0,  20'h12344, 1'b0, 20'hFFFDC, 20'hFFFDC, 3'd2, 4'd3}, // R3
    '{1'b0, 6'd1,  20'h12344, 1'b0, 20'hFFFE0, 20'hFFFE0, 3'd2, 4'd3}, // R3
    '{1'b0, 6'd3,  20'h00000, 1'b0, 20'hFFFE8, 20'hFFFE8, 3'd2, 4'd3}, // R3
    '{1'b0, 6'd4,  20'hABCDE, 1'b0, 20'hFFFEC, 20'hFFFEC, 3'd2, 4'd3}, // R3
    '{1'b0, 6'd5,  20'h00000, 1'b0, 20'hFFFF0, 20'hFFFF0, 3'd2, 4'd3}, // R3
    '{1'b0, 6'd6,  20'h00000, 1'b0, 20'hFFFF4, 20'hFFFF4, 3'd2, 4'd3}, // R3
    '{1'b0, 6'd7,  20'h00000, 1'b0, 20'hFFFF8, 20'hFFFF8, 3'd2, 4'd3}, // R3
    '{1'b0, 6'd8,  20'h00001, 1'b0, 20'hFFFFC, 20'hFFFFC, 3'd2, 4'd5}, // R5
    '{1'b0, 6'd12, 20'h55555, 1'b0, 20'hFFFFC, 20'hFFFFC, 3'd2, 4'd3}, // R3 high code
    '{1'b1, 6'd5,  20'h40000, 1'b0, 20'h40014, 20'h40014, 3'd2, 4'd4}, // R4 R7
    '{1'b1, 6'd63, 20'h40001, 1'b0, 20'h400FD, 20'h400FC, 3'd3, 4'd8}, // R8
    '{1'b1, 6'd0,  20'hFFFFF, 1'b0, 20'hFFFFF, 20'hFFFFE, 3'd3, 4'd8}, // R8 wrap
    '{1'b1, 6'd63, 20'hFFF80, 1'b0, 20'h0007C, 20'h0007C, 3'd2, 4'd4}, // R4 wrap
    '{1'b0, 6'd2,  20'h20000, 1'b0, 20'hFFFE4, 20'hFFFE6, 3'd3, 4'd9}, // R9 no flag
    '{1'b0, 6'd2,  20'h20000, 1'b1, 20'h20000, 20'hFFFE6, 3'd3, 4'd9}, // R9 flag
    '{1'b0, 6'd2,  20'h20003, 1'b1, 20'h20003, 20'hFFFE6, 3'd4, 4'd9}, // R9 flag odd
    '{1'b1, 6'd2,  20'h20000, 1'b1, 20'h20008, 20'h20008, 3'd2, 4'd4}  // R4 flag no effect
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic        srcKind = 1'b0;
  logic [5:0]  srcNum = '0;
  logic [19:0] tableBase = '0;
  logic        busy;
  logic [19:0] memAddr;
  logic        memRd;
  logic [15:0] memRdata = '0;
  logic        memReady = 1'b0;
  logic [19:0] vecAddr;
  logic        done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int memWait = 0;
  int waitCnt = 0;
  int rdCount = 0;
  logic [19:0] rdLog [8];
  logic brkFF = 1'b0;

  int_vector_fetch u_dut (
    .clk(clk), .rstN(rstN), .req(req), .srcKind(srcKind), .srcNum(srcNum),
    .tableBase(tableBase), .busy(busy), .memAddr(memAddr), .memRd(memRd),
    .memRdata(memRdata), .memReady(memReady), .vecAddr(vecAddr), .done(done)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] memByte(input logic [19:0] a);
    logic [7:0] t;
    if (a == 20'hFFFE7) return brkFF ? 8'hFF : 8'h5A;
    t = a[7:0] * 8'd13;
    return t ^ a[15:8] ^ {a[19:16], 4'h9};
  endfunction

  function automatic logic [19:0] expVec(input logic [19:0] e);
    logic [7:0] b2;
    b2 = memByte(e + 20'd2);
    return {b2[3:0], memByte(e + 20'd1), memByte(e)};
  endfunction

  // Memory model: answers a pending read after memWait cycles.
  always @(negedge clk) begin
    memReady = 1'b0;
    if (memRd && rstN) begin
      if (waitCnt >= memWait) begin
        memReady = 1'b1;
        memRdata = {memByte(memAddr + 20'd1), memByte(memAddr)};
        if (rdCount < 8) rdLog[rdCount] = memAddr;
        rdCount++;
        waitCnt = 0;
      end else begin
        waitCnt++;
      end
    end else begin
      waitCnt = 0;
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic startReq(input logic k, input logic [5:0] n, input logic [19:0] b);
    req = 1'b1; srcKind = k; srcNum = n; tableBase = b;
    rdCount = 0;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic waitDone(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit seen;
    logic [19:0] lastExp;
    logic [19:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0 && memRd == 0 && done == 0, "R1 idle outputs in reset", {busy, memRd, done}, 0);
    check(vecAddr == 0, "R1 vecAddr reset", vecAddr, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && memRd == 0, "R1 idle after reset release", {busy, memRd}, 0);

    for (int i = 0; i < NV; i++) begin
      memWait = i % 3;
      brkFF = VECS[i].ff;
      startReq(VECS[i].kind, VECS[i].num, VECS[i].base);
      waitDone(seen);
      check(seen, $sformatf("R10 done seen vec %0d", i), seen, 1);
      check(vecAddr == expVec(VECS[i].entry),
            $sformatf("R2/R%0d target vec %0d", VECS[i].reqId, i), vecAddr, expVec(VECS[i].entry));
      check(rdCount == int'(VECS[i].nRd),
            $sformatf("R7/R8/R9 read count vec %0d", i), rdCount, VECS[i].nRd);
      check(rdLog[0] == VECS[i].first,
            $sformatf("R6/R%0d first read vec %0d", VECS[i].reqId, i), rdLog[0], VECS[i].first);
      if (VECS[i].num == 6'd2 && !VECS[i].kind)
        lastExp = {VECS[i].entry[19:1], 1'b0} + 20'(2 * (VECS[i].nRd - 2));
      else
        lastExp = VECS[i].first + 20'(2 * (VECS[i].nRd - 1));
      check(rdLog[VECS[i].nRd - 1] == lastExp,
            $sformatf("R8 last read vec %0d", i), rdLog[VECS[i].nRd - 1], lastExp);
      check(busy == 0, "R10 busy low in done cycle", busy, 0);
      held = vecAddr;
      @(negedge clk);
      check(done == 0 && vecAddr == held, "R10 done one cycle, target held", {done, vecAddr}, {1'b0, held});
    end

    // R11: request during busy ignored
    memWait = 2;
    brkFF = 1'b0;
    startReq(1'b1, 6'd3, 20'h30000);
    check(busy == 1, "R12 busy after accept", busy, 1);
    req = 1'b1; srcKind = 1'b0; srcNum = 6'd0;
    @(negedge clk);
    req = 1'b0;
    waitDone(seen);
    check(vecAddr == expVec(20'h3000C), "R11 busy request ignored target", vecAddr, expVec(20'h3000C));
    check(rdCount == 2, "R11 read count", rdCount, 2);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(busy == 0 && done == 0, "R11 no second operation", {busy, done}, 0);
    end

    // R12: back-to-back request in the done cycle
    memWait = 0;
    startReq(1'b0, 6'd7, 20'h0);
    waitDone(seen);
    check(vecAddr == expVec(20'hFFFF8), "R12 first of pair", vecAddr, expVec(20'hFFFF8));
    req = 1'b1; srcKind = 1'b0; srcNum = 6'd1; rdCount = 0;
    @(negedge clk);
    req = 1'b0;
    check(busy == 1, "R12 accepted in done cycle", busy, 1);
    waitDone(seen);
    check(vecAddr == expVec(20'hFFFE0), "R12 second of pair", vecAddr, expVec(20'hFFFE0));

    // R1: reset aborts an operation in progress
    memWait = 2;
    startReq(1'b1, 6'd9, 20'h11111);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(busy == 0 && memRd == 0 && done == 0, "R1 abort outputs", {busy, memRd, done}, 0);
    check(vecAddr == 0, "R1 abort vecAddr", vecAddr, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule